// File: doc/BRIEF.md
# Queue Pointer Interrupt Generator

This block holds the head and tail pointers of four circular message queues and turns their state into level interrupts. Software or a trap unit advances a queue by writing one of its pointers through an indexed register port; while a queue's two pointers differ the queue holds at least one entry. Three queues raise an interrupt while non-empty: the processor-message queue, the device-message queue and the recoverable-error queue. The fourth, the fatal-error queue, is storage only and signals nothing.

The block also stores a hypervisor state word. It raises a level-zero interrupt when that word requests notification on return to trap level zero, the current trap level (an input) is zero, and the word's hyperprivilege bit is clear. Every interrupt output is a combinational function of stored state and the trap-level input. It therefore changes in the cycle that follows the clock edge that captured a write.

Top module: `hqi_irq_gen`

## Requirements
- R1: `irq_cpu_q` is high exactly while the processor-message head (index 0) differs from its tail (index 1).
- R2: `irq_dev_q` is high exactly while the device-message head (index 2) differs from its tail (index 3).
- R3: `irq_rerr_q` is high exactly while the recoverable-error head (index 4) differs from its tail (index 5).
- R4: The fatal-error head (index 6) and tail (index 7) are written and read back like the other pointers, and no output interrupt depends on them.
- R5: A write to either pointer of a pair is visible on that pair's interrupt after the clock edge that captures it, in the next cycle.
- R6: Every write to the hypervisor state word (index 8) stores bits [HV_W-1:0] of the write data with bit 11 forced to 1.
- R7: `irq_lvl0` is high exactly when hypervisor state bit 0 is 1, bit 2 is 0 and `tl_i` is zero.
- R8: After a synchronous reset all pointers and the state word are zero, so every interrupt is low.
- R9: Reading an index above 8 returns zero; writing one changes no stored register and no output.
- R10: A pointer stores the low PTR_W bits of the write data. A read returns them zero-extended, combinationally from `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | DATA_W | Write data |
| rd_idx | input | IDX_W | Register index of the read |
| rd_data | output | DATA_W | Read data, combinational |
| tl_i | input | TL_W | Current trap level |
| irq_cpu_q | output | 1 | Processor-message queue non-empty |
| irq_dev_q | output | 1 | Device-message queue non-empty |
| irq_rerr_q | output | 1 | Recoverable-error queue non-empty |
| irq_lvl0 | output | 1 | Trap-level-zero interrupt |

## Verification
The hardest case to reach is a queue that returns to empty. This happens only when a written pointer matches the other pointer bit for bit, and wide random data almost never does that. The stimulus therefore draws most pointer values from a set of four. This makes equal and unequal pairs common for every queue, the fatal-error one included. The level-zero interrupt depends on three conditions, so the bench changes the trap-level input on its own while writing state words that cover each combination of the two control bits.

// File: rtl/hqi_pkg.sv
// Package: register map and hypervisor state bit positions for the queue
// pointer interrupt generator. The map places the pointer pairs first so that
// index bit 0 selects head or tail and the bits above it select the queue.
package hqi_pkg;
    localparam int NUM_Q    = 4;
    localparam int Q_CPU    = 0;
    localparam int Q_DEV    = 1;
    localparam int Q_RERR   = 2;
    localparam int Q_FATAL  = 3;
    localparam int HV_IDX   = 2 * NUM_Q;   // state word sits after the pairs
    localparam int HV_LVL0  = 0;           // request level-zero notification
    localparam int HV_PRIV  = 2;           // hyperprivileged mode
    localparam int HV_ID    = 11;          // implementation bit, always 1
endpackage

// File: rtl/hqi_ptr_pair.sv
// Module: one head/tail pointer pair of a circular queue.
// Stores both pointers. When GEN_IRQ is set it flags "non-empty" while they
// differ; otherwise the flag is tied low. Assumes the tail index is the head
// index plus one.
module hqi_ptr_pair #(
    parameter int PTR_W    = 14,
    parameter int IDX_W    = 4,
    parameter int HEAD_IDX = 0,
    parameter bit GEN_IRQ  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic             irq_o
);
    localparam logic [IDX_W-1:0] H_IDX = IDX_W'(HEAD_IDX);
    localparam logic [IDX_W-1:0] T_IDX = IDX_W'(HEAD_IDX + 1);

    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;

    // Capture head or tail on a write that addresses this pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (wr_en) begin
            if (wr_idx == H_IDX) head_q <= wr_ptr;
            if (wr_idx == T_IDX) tail_q <= wr_ptr;
        end
    end

    assign head_o = head_q;
    assign tail_o = tail_q;

    generate
        if (GEN_IRQ) begin : g_irq
            // Non-empty flag follows the stored pointers.
            assign irq_o = (head_q != tail_q);

            // R5
            head_match_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == H_IDX && wr_ptr == tail_q) |=> !irq_o);
            // R5
            tail_miss_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == T_IDX && wr_ptr != head_q) |=> irq_o);
        end else begin : g_noirq
            // Storage-only queue: no interrupt.
            assign irq_o = 1'b0;
        end
    endgenerate

    // R8
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (head_q == '0 && tail_q == '0));
endmodule

// File: rtl/hqi_hv_state.sv
// Module: hypervisor state word and trap-level-zero interrupt.
// A write forces the implementation ID bit high. The interrupt is combinational
// from the stored word and the live trap level. Assumes HV_W > HV_ID.
module hqi_hv_state
    import hqi_pkg::*;
#(
    parameter int HV_W  = 12,
    parameter int IDX_W = 4,
    parameter int TL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [HV_W-1:0]  wr_val,
    input  logic [TL_W-1:0]  tl_i,
    output logic [HV_W-1:0]  hv_o,
    output logic             irq_lvl0_o
);
    localparam logic [IDX_W-1:0] MY_IDX  = IDX_W'(HV_IDX);
    localparam logic [HV_W-1:0]  ID_MASK = HV_W'(1) << HV_ID;

    logic [HV_W-1:0] hv_q;

    // Store the written word with the ID bit set.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hv_q <= '0;
        else if (wr_en && wr_idx == MY_IDX)   hv_q <= wr_val | ID_MASK;
    end

    assign hv_o = hv_q;

    // Level-zero request, not in hyperprivileged mode, at trap level zero.
    always_comb begin
        irq_lvl0_o = hv_q[HV_LVL0] && !hv_q[HV_PRIV] && (tl_i == '0);
    end

    // R6
    id_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == MY_IDX) |=> hv_o[HV_ID]);
    // R7
    lvl0_at_tl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_i != '0) |-> !irq_lvl0_o);
endmodule

// File: rtl/hqi_rd_mux.sv
// Module: combinational read selector over the pointer pairs and state word.
// Index bit 0 picks head/tail and the bits above pick the queue. Unmapped
// indices read zero. Assumes DATA_W >= PTR_W and DATA_W >= HV_W.
module hqi_rd_mux
    import hqi_pkg::*;
#(
    parameter int PTR_W  = 14,
    parameter int HV_W   = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [NUM_Q-1:0][PTR_W-1:0]  heads,
    input  logic [NUM_Q-1:0][PTR_W-1:0]  tails,
    input  logic [HV_W-1:0]              hv,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int QS_W = $clog2(NUM_Q);

    logic [QS_W-1:0] q_sel;
    assign q_sel = rd_idx[QS_W:1];

    // Select the addressed register, zero-extended.
    always_comb begin
        rd_data = '0;
        if (rd_idx < IDX_W'(2 * NUM_Q)) begin
            rd_data = DATA_W'(rd_idx[0] ? tails[q_sel] : heads[q_sel]);
        end else if (rd_idx == IDX_W'(HV_IDX)) begin
            rd_data = DATA_W'(hv);
        end
    end

    // R9
    always_comb begin
        if (rd_idx > IDX_W'(HV_IDX)) begin
            unmapped_zero_chk: assert (rd_data == '0);
        end
    end
endmodule

// File: rtl/hqi_irq_gen.sv
// Module: queue pointer interrupt generator, top level.
// Four pointer pairs (the last one without interrupt), a hypervisor state
// word, and an indexed write/read port. Assumes PTR_W >= HV_W and
// DATA_W >= PTR_W.
module hqi_irq_gen
    import hqi_pkg::*;
#(
    parameter int PTR_W  = 14,
    parameter int HV_W   = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64,
    parameter int TL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TL_W-1:0]   tl_i,
    output logic              irq_cpu_q,
    output logic              irq_dev_q,
    output logic              irq_rerr_q,
    output logic              irq_lvl0
);
    logic [NUM_Q-1:0][PTR_W-1:0] heads;
    logic [NUM_Q-1:0][PTR_W-1:0] tails;
    logic [NUM_Q-1:0]            irq_vec;
    logic [HV_W-1:0]             hv;
    logic                        unused_bits;

    // Bits no register stores.
    assign unused_bits = ^{wr_data[DATA_W-1:PTR_W], irq_vec[Q_FATAL]};

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_pair
            hqi_ptr_pair #(
                .PTR_W   (PTR_W),
                .IDX_W   (IDX_W),
                .HEAD_IDX(2 * q),
                .GEN_IRQ (q != Q_FATAL)
            ) u_pair (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_en),
                .wr_idx(wr_idx),
                .wr_ptr(wr_data[PTR_W-1:0]),
                .head_o(heads[q]),
                .tail_o(tails[q]),
                .irq_o (irq_vec[q])
            );
        end
    endgenerate

    hqi_hv_state #(
        .HV_W (HV_W),
        .IDX_W(IDX_W),
        .TL_W (TL_W)
    ) u_hv (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_data[HV_W-1:0]),
        .tl_i      (tl_i),
        .hv_o      (hv),
        .irq_lvl0_o(irq_lvl0)
    );

    hqi_rd_mux #(
        .PTR_W (PTR_W),
        .HV_W  (HV_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_rd (
        .rd_idx (rd_idx),
        .heads  (heads),
        .tails  (tails),
        .hv     (hv),
        .rd_data(rd_data)
    );

    assign irq_cpu_q  = irq_vec[Q_CPU];
    assign irq_dev_q  = irq_vec[Q_DEV];
    assign irq_rerr_q = irq_vec[Q_RERR];

    // R9
    unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > IDX_W'(HV_IDX)) |=> $stable({irq_cpu_q, irq_dev_q, irq_rerr_q}));
    // R4
    fatal_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(6) || wr_idx == IDX_W'(7)))
        |=> $stable({irq_cpu_q, irq_dev_q, irq_rerr_q}));
endmodule

// File: tb/sim_hqi_irq_gen.sv
// Bench: behavioural register model updated on each rising edge, compared
// with every output at the falling edge.
module sim_hqi_irq_gen;
    localparam int PTR_W = 14, HV_W = 12, IDX_W = 4, DATA_W = 64, TL_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [DATA_W-1:0] rd_data;
    logic [TL_W-1:0]   tl_i = '0;
    logic              irq_cpu_q, irq_dev_q, irq_rerr_q, irq_lvl0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Reference state: eight pointers and the state word.
    logic [PTR_W-1:0] m_ptr [8];
    logic [HV_W-1:0]  m_hv;

    hqi_irq_gen #(.PTR_W(PTR_W), .HV_W(HV_W), .IDX_W(IDX_W),
                  .DATA_W(DATA_W), .TL_W(TL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .tl_i(tl_i),
        .irq_cpu_q(irq_cpu_q), .irq_dev_q(irq_dev_q),
        .irq_rerr_q(irq_rerr_q), .irq_lvl0(irq_lvl0));

    always #10 clk = ~clk;

    // Model update at the active edge.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_ptr[i] <= '0;
            m_hv <= '0;
        end else if (wr_en) begin
            if (int'(wr_idx) < 8) m_ptr[wr_idx[2:0]] <= wr_data[PTR_W-1:0];
            else if (int'(wr_idx) == 8) m_hv <= wr_data[HV_W-1:0] | 12'h800;
        end
    end

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_rd(int idx);
        if (idx < 8) return DATA_W'(m_ptr[idx]);
        if (idx == 8) return DATA_W'(m_hv);
        return '0;
    endfunction

    // Compare all outputs at the falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1/R5 irq_cpu_q",  64'(irq_cpu_q),  64'(m_ptr[0] != m_ptr[1]));
            chk("R2/R5 irq_dev_q",  64'(irq_dev_q),  64'(m_ptr[2] != m_ptr[3]));
            chk("R3/R5 irq_rerr_q", 64'(irq_rerr_q), 64'(m_ptr[4] != m_ptr[5]));
            chk("R7 irq_lvl0", 64'(irq_lvl0),
                64'(m_hv[0] && !m_hv[2] && tl_i == 0));
            if (int'(rd_idx) < 6)       chk("R10 read ptr", rd_data, exp_rd(int'(rd_idx)));
            else if (int'(rd_idx) < 8)  chk("R4 read fatal ptr", rd_data, exp_rd(int'(rd_idx)));
            else if (int'(rd_idx) == 8) chk("R6 read state", rd_data, exp_rd(8));
            else                        chk("R9 read unmapped", rd_data, 64'd0);
        end
    end

    // One cycle of stimulus, driven clear of the edge.
    task automatic step(bit we, int widx, logic [DATA_W-1:0] wd, int ridx, int tl);
        @(posedge clk);
        #5;
        wr_en = we; wr_idx = IDX_W'(widx); wr_data = wd;
        rd_idx = IDX_W'(ridx); tl_i = TL_W'(tl);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R8: reset state seen at the ports
        #5;
        chk("R8 irq_cpu_q", 64'(irq_cpu_q), 64'd0);
        chk("R8 irq_dev_q", 64'(irq_dev_q), 64'd0);
        chk("R8 irq_rerr_q", 64'(irq_rerr_q), 64'd0);
        chk("R8 irq_lvl0", 64'(irq_lvl0), 64'd0);
        for (int i = 0; i < 9; i++) begin
            rd_idx = IDX_W'(i); #1;
            chk("R8 read zero", rd_data, 64'd0);
        end
        cmp_on = 1'b1;
        // R1, R5: head moves then tail catches up
        step(1, 0, 64'd5, 0, 0);
        step(1, 1, 64'd5, 1, 0);
        step(0, 0, 64'd0, 0, 0);
        // R2, R3: same for device and recoverable-error queues
        step(1, 3, 64'd9, 3, 0);
        step(1, 2, 64'd9, 2, 0);
        step(1, 4, 64'd1, 4, 0);
        step(1, 5, 64'd2, 5, 0);
        step(1, 5, 64'd1, 5, 0);
        // R4: fatal-error pair differs, no interrupt
        step(1, 6, 64'd7, 6, 0);
        step(1, 7, 64'd3, 7, 0);
        step(0, 0, 64'd0, 6, 0);
        // R10: upper data bits dropped
        step(1, 0, 64'hFFFF_FFFF_FFFF_C003, 0, 0);
        step(1, 1, 64'd3, 0, 0);
        // R6, R7: state word combinations with trap level
        step(1, 8, 64'h0, 8, 0);
        step(1, 8, 64'h1, 8, 0);
        step(0, 0, 64'h0, 8, 2);
        step(1, 8, 64'h5, 8, 0);
        step(1, 8, 64'hFFFF_F001, 8, 0);
        // R9: unmapped writes and reads
        step(1, 9, 64'd1, 9, 0);
        step(1, 15, 64'hFF, 15, 0);
        step(1, 12, 64'd3, 0, 0);
        // Random mix with small pointer values
        for (int n = 0; n < 600; n++) begin
            step(($urandom % 4) != 0, $urandom % 12,
                 (($urandom % 8) == 0) ? {$urandom, $urandom} : 64'($urandom % 4),
                 $urandom % 16, (($urandom % 2) == 0) ? 0 : $urandom % 8);
        end
        step(0, 0, 64'd0, 0, 0);
        @(posedge clk); #15;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 50000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<50000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule